// File: doc/BRIEF.md
# VGA Indexed Register Port

This block holds the sequencer and graphics-controller register files of a VGA-style display device. Software reaches these registers through two pairs of I/O ports. In each pair, one port selects a register and the other port stores a byte into the selected register. The block decodes a write bus that carries a 16-bit port address, a data value and a size of one or two bytes. It stores each byte with only the bits that register keeps. It then reports, one cycle later, whether the byte was taken.

Every register value is driven out in parallel to downstream display logic. The block also drives a standard-mode flag, which is high whenever sequencer register 7 is zero. A one-cycle pulse marks the moment that flag switches on. A two-byte write is split into two byte writes on consecutive cycles: the low byte goes to the addressed port, then the high byte goes to the next port. One word write can therefore select a register and fill it. While the second byte is pending, a busy output holds off new requests.

Top module: `vga_idx_regs`

## Requirements
- R1: After synchronous active-high reset, every register and both selectors read zero. `busy`, `ack` and `std_enter` are low, and `std_mode` is high.
- R2: A byte written to port 0x3C4 becomes the sequencer selector, held as all 8 bits. A byte written to port 0x3C5 is stored into sequencer register [selector] ANDed with that register's keep mask. The masks for registers 0..7 are 03,3D,0F,3F,0E,00,00,FF (hex). Register k appears on `seq_regs[8k+7:8k]`.
- R3: A byte written to port 0x3CE becomes the graphics selector, held as all 8 bits. A byte written to port 0x3CF is stored into graphics register [selector] ANDed with its keep mask. The masks for registers 0..8 are 0F,0F,0F,1F,03,7B,0F,0F,FF (hex). Register k appears on `gfx_regs[8k+7:8k]`.
- R4: A data-port byte whose selector is at or above the register count (8 for sequencer, 9 for graphics) changes no register and is reported with `ack_ok`=0.
- R5: A byte written to any port other than the four above changes no register or selector and is reported with `ack_ok`=0.
- R6: Each applied byte gives `ack`=1 in the following cycle. In that cycle `ack_ok` is 1 exactly when the byte was stored (selector ports always; data ports only when the selector is in range). With no byte applied, `ack` is 0.
- R7: A request with `req_word`=1 applies `req_data[7:0]` to `req_port` at its accepting edge. It then applies `req_data[15:8]` to `req_port`+1 at the next edge, with `busy` high in between. This gives two `ack` cycles in a row.
- R8: A request presented while `busy` is high is ignored. It is neither applied nor queued.
- R9: `std_mode` is 1 exactly when sequencer register 7 is 0x00. `std_enter` is high for one cycle right after `std_mode` rises and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request strobe |
| req_port | input | 16 | I/O port address |
| req_data | input | 16 | Write data; upper byte used only for word writes |
| req_word | input | 1 | 1 = two-byte write, 0 = one-byte write |
| busy | output | 1 | High while the second byte of a word write is pending |
| ack | output | 1 | A byte was applied in the previous cycle |
| ack_ok | output | 1 | The byte reported by `ack` was stored |
| seq_regs | output | 64 | Sequencer registers 0..7, byte k at bits 8k+7:8k |
| gfx_regs | output | 72 | Graphics registers 0..8, byte k at bits 8k+7:8k |
| std_mode | output | 1 | Sequencer register 7 is zero |
| std_enter | output | 1 | One-cycle pulse when `std_mode` rises |

## Verification
A wrong selector value shows up on the next data-port byte, and the effect lands on the very next `ack` cycle. Either the wrong byte lane of `seq_regs` or `gfx_regs` changes, or `ack_ok` takes the wrong value. A wrong keep mask shows in the stored byte one cycle after the write. The sweep writes every value into every register, so each masked bit is exposed both set and clear. A stale pending word byte shows as an extra or missing `ack` and a `busy` level that differs from the expected one-cycle window. A lost previous-mode flag shows as a missing or doubled `std_enter` in the cycle after register 7 crosses zero.

// File: rtl/vga_idx_regs.sv
module vga_idx_regs #(
  parameter logic [15:0] SEQ_PORT = 16'h03C4,
  parameter logic [15:0] GFX_PORT = 16'h03CE,
  parameter int SEQ_N = 8,
  parameter int GFX_N = 9,
  parameter int MODE_REG = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [15:0]          req_port,
  input  logic [15:0]          req_data,
  input  logic                 req_word,
  output logic                 busy,
  output logic                 ack,
  output logic                 ack_ok,
  output logic [SEQ_N*8-1:0]   seq_regs,
  output logic [GFX_N*8-1:0]   gfx_regs,
  output logic                 std_mode,
  output logic                 std_enter
);

  function automatic logic [7:0] seq_keep(input int i);
    case (i)
      0: return 8'h03;
      1: return 8'h3D;
      2: return 8'h0F;
      3: return 8'h3F;
      4: return 8'h0E;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] gfx_keep(input int i);
    case (i)
      3: return 8'h1F;
      4: return 8'h03;
      5: return 8'h7B;
      8: return 8'hFF;
      default: return 8'h0F;
    endcase
  endfunction

  logic [7:0]  seq_q [SEQ_N];
  logic [7:0]  gfx_q [GFX_N];
  logic [7:0]  sidx_q, gidx_q;
  logic        pend_q, mode_q;
  logic [15:0] pend_port_q;
  logic [7:0]  pend_byte_q;

  logic        go, take;
  logic [15:0] cur_port;
  logic [7:0]  cur_byte;
  logic        hit_sidx, hit_sdat, hit_gidx, hit_gdat;
  logic        s_in, g_in, go_ok;

  assign take     = req_valid & ~pend_q;
  assign go       = take | pend_q;
  assign cur_port = pend_q ? pend_port_q : req_port;
  assign cur_byte = pend_q ? pend_byte_q : req_data[7:0];

  assign hit_sidx = cur_port == SEQ_PORT;
  assign hit_sdat = cur_port == SEQ_PORT + 16'd1;
  assign hit_gidx = cur_port == GFX_PORT;
  assign hit_gdat = cur_port == GFX_PORT + 16'd1;
  assign s_in     = 32'(sidx_q) < SEQ_N;
  assign g_in     = 32'(gidx_q) < GFX_N;
  assign go_ok    = go & (hit_sidx | hit_gidx | (hit_sdat & s_in) | (hit_gdat & g_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SEQ_N; k++) seq_q[k] <= '0;
      for (int k = 0; k < GFX_N; k++) gfx_q[k] <= '0;
      sidx_q      <= '0;
      gidx_q      <= '0;
      pend_q      <= 1'b0;
      pend_port_q <= '0;
      pend_byte_q <= '0;
      ack         <= 1'b0;
      ack_ok      <= 1'b0;
    end else begin
      ack    <= go;
      ack_ok <= go_ok;
      if (go) begin
        if (hit_sidx) sidx_q <= cur_byte;
        if (hit_gidx) gidx_q <= cur_byte;
        if (hit_sdat)
          for (int k = 0; k < SEQ_N; k++)
            if (sidx_q == 8'(k)) seq_q[k] <= cur_byte & seq_keep(k);
        if (hit_gdat)
          for (int k = 0; k < GFX_N; k++)
            if (gidx_q == 8'(k)) gfx_q[k] <= cur_byte & gfx_keep(k);
      end
      if (take && req_word) begin
        pend_q      <= 1'b1;
        pend_port_q <= req_port + 16'd1;
        pend_byte_q <= req_data[15:8];
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b1;
    else     mode_q <= std_mode;
  end

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq_out
    assign seq_regs[g*8 +: 8] = seq_q[g];
  end
  for (genvar g = 0; g < GFX_N; g++) begin : g_gfx_out
    assign gfx_regs[g*8 +: 8] = gfx_q[g];
  end

  assign busy      = pend_q;
  assign std_mode  = seq_q[MODE_REG] == 8'h00;
  assign std_enter = std_mode & ~mode_q;

endmodule

// File: rtl/vga_idx_regs_chk.sv
module vga_idx_regs_chk #(
  parameter int SEQ_N = 8,
  parameter int GFX_N = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_word,
  input logic               busy,
  input logic               ack,
  input logic               ack_ok,
  input logic [SEQ_N*8-1:0] seq_regs,
  input logic [GFX_N*8-1:0] gfx_regs,
  input logic               std_mode,
  input logic               std_enter
);

  a_r7_word_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_word) |=> busy);

  a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  a_r7_second_byte_acked: assert property (@(posedge clk) disable iff (rst)
    busy |=> ack);

  a_r6_idle_no_ack: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !busy) |=> !ack);

  a_r6_ok_needs_ack: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> ack);

  a_r4_rejected_no_change: assert property (@(posedge clk) disable iff (rst)
    (ack && !ack_ok) |-> ($stable(seq_regs) && $stable(gfx_regs)));

  a_r9_enter_in_mode: assert property (@(posedge clk) disable iff (rst)
    std_enter |-> (std_mode && !$past(std_mode)));

  a_r9_enter_single: assert property (@(posedge clk) disable iff (rst)
    std_enter |=> !std_enter);

endmodule

bind vga_idx_regs vga_idx_regs_chk #(.SEQ_N(SEQ_N), .GFX_N(GFX_N)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
  .busy(busy), .ack(ack), .ack_ok(ack_ok), .seq_regs(seq_regs),
  .gfx_regs(gfx_regs), .std_mode(std_mode), .std_enter(std_enter)
);

// File: tb/sim_vga_idx_regs.sv
module sim_vga_idx_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_port = '0;
  logic [15:0] req_data = '0;
  logic        req_word = 1'b0;
  logic        busy, ack, ack_ok, std_mode, std_enter;
  logic [63:0] seq_regs;
  logic [71:0] gfx_regs;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_idx_regs u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_data(req_data), .req_word(req_word), .busy(busy), .ack(ack),
    .ack_ok(ack_ok), .seq_regs(seq_regs), .gfx_regs(gfx_regs),
    .std_mode(std_mode), .std_enter(std_enter)
  );

  localparam logic [7:0] SK [8] = '{8'h03, 8'h3D, 8'h0F, 8'h3F, 8'h0E, 8'h00, 8'h00, 8'hFF};
  localparam logic [7:0] GK [9] = '{8'h0F, 8'h0F, 8'h0F, 8'h1F, 8'h03, 8'h7B, 8'h0F, 8'h0F, 8'hFF};

  int checks = 0;
  int failures = 0;
  logic [7:0] m_seq [8];
  logic [7:0] m_gfx [9];
  logic [7:0] m_sidx, m_gidx;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_seq_flat();
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = m_seq[k];
    return r;
  endfunction

  function automatic logic [71:0] m_gfx_flat();
    logic [71:0] r;
    for (int k = 0; k < 9; k++) r[k*8 +: 8] = m_gfx[k];
    return r;
  endfunction

  task automatic model_byte(input logic [15:0] p, input logic [7:0] b,
                            output logic ok, output logic ent);
    logic old_zero;
    old_zero = (m_seq[7] == 8'h00);
    ok = 1'b0;
    case (p)
      16'h03C4: begin m_sidx = b; ok = 1'b1; end
      16'h03CE: begin m_gidx = b; ok = 1'b1; end
      16'h03C5: if (m_sidx < 8) begin m_seq[m_sidx[2:0]] = b & SK[m_sidx[2:0]]; ok = 1'b1; end
      16'h03CF: if (m_gidx < 9) begin m_gfx[m_gidx[3:0]] = b & GK[m_gidx[3:0]]; ok = 1'b1; end
      default: ok = 1'b0;
    endcase
    ent = (m_seq[7] == 8'h00) && !old_zero;
  endtask

  task automatic check_after(string req, logic exp_ok, logic exp_ent, logic exp_busy);
    chk(req, "ack", 128'(ack), 128'(1'b1));
    chk(req, "ack_ok", 128'(ack_ok), 128'(exp_ok));
    chk(req, "busy", 128'(busy), 128'(exp_busy));
    chk(req, "seq_regs", 128'(seq_regs), 128'(m_seq_flat()));
    chk(req, "gfx_regs", 128'(gfx_regs), 128'(m_gfx_flat()));
    chk("R9", "std_mode", 128'(std_mode), 128'(m_seq[7] == 8'h00));
    chk("R9", "std_enter", 128'(std_enter), 128'(exp_ent));
  endtask

  task automatic wr(input logic [15:0] p, input logic [15:0] d, input logic word, input string req);
    logic ok, ent;
    @(negedge clk);
    req_valid = 1'b1; req_port = p; req_data = d; req_word = word;
    @(negedge clk);
    req_valid = 1'b0; req_word = 1'b0;
    model_byte(p, d[7:0], ok, ent);
    check_after(req, ok, ent, word);
    if (word) begin
      @(negedge clk);
      model_byte(p + 16'd1, d[15:8], ok, ent);
      check_after(req, ok, ent, 1'b0);
    end
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    chk(req, "idle ack", 128'(ack), 128'(1'b0));
    chk(req, "idle busy", 128'(busy), 128'(1'b0));
    chk("R9", "idle std_enter", 128'(std_enter), 128'(1'b0));
    chk(req, "idle seq_regs", 128'(seq_regs), 128'(m_seq_flat()));
    chk(req, "idle gfx_regs", 128'(gfx_regs), 128'(m_gfx_flat()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ok, ent;
    for (int k = 0; k < 8; k++) m_seq[k] = '0;
    for (int k = 0; k < 9; k++) m_gfx[k] = '0;
    m_sidx = '0; m_gidx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "seq_regs", 128'(seq_regs), 128'(0));
    chk("R1", "gfx_regs", 128'(gfx_regs), 128'(0));
    chk("R1", "busy", 128'(busy), 128'(0));
    chk("R1", "ack", 128'(ack), 128'(0));
    chk("R1", "std_mode", 128'(std_mode), 128'(1));
    chk("R1", "std_enter", 128'(std_enter), 128'(0));
    // R1 selectors start at zero: data byte lands in register 0
    wr(16'h03C5, 16'h00FF, 1'b0, "R1");
    wr(16'h03CF, 16'h00FF, 1'b0, "R1");

    // R2 / R7 full sweep through word writes (R9 via register 7)
    for (int i = 0; i < 8; i++)
      for (int v = 0; v < 256; v++)
        wr(16'h03C4, {8'(v), 8'(i)}, 1'b1, "R2");
    // R3 full sweep
    for (int i = 0; i < 9; i++)
      for (int v = 0; v < 256; v++)
        wr(16'h03CE, {8'(v), 8'(i)}, 1'b1, "R3");

    // R6 byte-form selector then data
    for (int i = 0; i < 8; i++) begin
      wr(16'h03C4, 16'(i), 1'b0, "R6");
      wr(16'h03C5, 16'h00A5 ^ 16'(i), 1'b0, "R6");
    end
    for (int i = 0; i < 9; i++) begin
      wr(16'h03CE, 16'(i), 1'b0, "R6");
      wr(16'h03CF, 16'h005A ^ 16'(i), 1'b0, "R6");
    end
    idle_check("R6");

    // R4 out-of-range selectors kept and rejected
    for (int i = 8; i < 256; i++) wr(16'h03C4, {8'hFF, 8'(i)}, 1'b1, "R4");
    for (int i = 9; i < 256; i++) wr(16'h03CE, {8'hFF, 8'(i)}, 1'b1, "R4");
    wr(16'h03C5, 16'h0077, 1'b0, "R4");
    wr(16'h03CF, 16'h0077, 1'b0, "R4");

    // R5 unrelated ports
    for (int p = 16'h03B0; p < 16'h03E0; p++)
      if (p != 16'h03C4 && p != 16'h03C5 && p != 16'h03CE && p != 16'h03CF)
        wr(16'(p), 16'h00A5, 1'b0, "R5");
    wr(16'h1234, 16'h00C4, 1'b0, "R5");

    // R7 word at the port below the selector: high byte lands on the selector
    wr(16'h03C3, 16'h0299, 1'b1, "R7");
    wr(16'h03C5, 16'h00FF, 1'b0, "R7");

    // R9 enter pulse
    wr(16'h03C4, 16'h0107, 1'b1, "R9");
    idle_check("R9");
    wr(16'h03C5, 16'h0000, 1'b0, "R9");
    idle_check("R9");
    wr(16'h03C5, 16'h0000, 1'b0, "R9");

    // R8 request during busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_port = 16'h03C4; req_data = 16'h3A01; req_word = 1'b1;
    @(negedge clk);
    model_byte(16'h03C4, 8'h01, ok, ent);
    check_after("R8", ok, ent, 1'b1);
    req_port = 16'h03C4; req_data = 16'h0003; req_word = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    model_byte(16'h03C5, 8'h3A, ok, ent);
    check_after("R8", ok, ent, 1'b0);
    idle_check("R8");
    wr(16'h03C5, 16'h00FF, 1'b0, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule